// File: doc/BRIEF.md
# ADC Result Serial Readout Port

This block is the host-facing serial port of a converter. A strobe from the conversion core hands it a 16-bit result. The port keeps that result in a holding register and then raises its active-low ready flag to the blocked state for a fixed number of master-clock cycles. When that window ends, and no output word is partly shifted, it moves the result into the output data register and drives the ready flag low. The host then pulls the word out, most significant bit first. The flag returns high once the full word has been read. A new result that arrives while a word is partly shifted waits until that word completes, so a word never mixes two results.

Chip select, serial clock and data input are each brought into the master-clock domain through a chain of flops, and edges are detected there. The port is full duplex. Each qualified rising serial-clock edge advances the output word and also shifts one data-input bit into an 8-bit command register. Words are framed only by counting edges and never by chip-select edges. This allows a host to tie chip select low and run the port on three wires.

Top module: `adc_serial_port`

## Requirements
- R1: While reset is asserted, and after it is released, drdy_no is 1, dout_en_o and dout_o are 0 and cmd_valid_o is 0. Reset also clears the bit counters, so the next word and byte start at their first bit.
- R2: A cycle with result_valid_i high captures result_i, and drdy_no is 1 in the following cycle.
- R3: After the last result_valid_i, drdy_no stays 1 for exactly BLANK_CYCLES clock cycles. The output data register is then loaded and drdy_no goes 0, provided no word is partly shifted.
- R4: dout_o carries the data register MSB first. Bit 15-n is presented for the (n+1)-th qualified rising serial-clock edge of a word. It changes 3 clock cycles after a falling serial-clock edge.
- R5: drdy_no returns to 1 three clock cycles after the 16th qualified rising serial-clock edge of a word.
- R6: A result that becomes due while a word is partly shifted is held back. The word being read keeps its old value, and the new result loads one cycle after that word completes.
- R7: dout_en_o is the inverse of cs_ni, delayed by 2 clock cycles. While it is 0, dout_o is 0 and the pad is expected to float.
- R8: Chip-select edges do not reset the word position. A word may be split across several chip-select periods or read with chip select held low throughout.
- R9: Serial-clock edges while chip select is high do not advance the word position and do not capture din_i.
- R10: Every 8 qualified rising edges, the 8 bits sampled on din_i appear on cmd_byte_o, with the first bit in bit 7. cmd_valid_o pulses for one cycle, 3 clock cycles after the 8th edge.
- R11: A result arriving during a blanking window restarts the window, and the latest result is the one loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| result_valid_i | input | 1 | New result strobe from the conversion core |
| result_i | input | DATA_W | Conversion result |
| cs_ni | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock from the host |
| din_i | input | 1 | Serial data from the host |
| dout_o | output | 1 | Serial data to the host |
| dout_en_o | output | 1 | Output driver enable for dout_o |
| drdy_no | output | 1 | Result ready flag, active low |
| cmd_byte_o | output | CMD_W | Last complete command byte |
| cmd_valid_o | output | 1 | One-cycle strobe for cmd_byte_o |

## Verification
The bench builds the port with a 16-bit word, an 8-bit command byte and two synchroniser stages. BLANK_CYCLES is shortened to 12, so that several blanking windows fit in a short run. This makes it possible to check within a few hundred cycles the exact cycle in which a window ends, a window restarted by a second result, and a result held back behind a half-read word. The serial clock runs at one eighth of the master clock. Under this setting words are split across chip-select periods, and edges are sent while chip select is high.

// File: rtl/adc_sport_pkg.sv
package adc_sport_pkg;
  // serial inputs after synchronisation, edges already detected
  typedef struct packed {
    logic active;
    logic rise;
    logic fall;
    logic din;
  } ser_evt_t;
endpackage

// File: rtl/adc_sport_sync.sv
module adc_sport_sync
  import adc_sport_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     cs_ni,
  input  logic     sclk_i,
  input  logic     din_i,
  output ser_evt_t evt_o
);
  // bit 2 cs, bit 1 sclk, bit 0 din; idle bus is cs high, sclk high
  localparam logic [2:0] RST_V = 3'b110;

  logic [2:0] stage_q [STAGES];
  logic       sclk_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_V;
      sclk_prev_q <= 1'b1;
    end else begin
      stage_q[0] <= {cs_ni, sclk_i, din_i};
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
      sclk_prev_q <= stage_q[STAGES-1][1];
    end
  end

  assign evt_o.active = ~stage_q[STAGES-1][2];
  assign evt_o.rise   =  stage_q[STAGES-1][1] & ~sclk_prev_q;
  assign evt_o.fall   = ~stage_q[STAGES-1][1] &  sclk_prev_q;
  assign evt_o.din    =  stage_q[STAGES-1][0];
endmodule

// File: rtl/adc_sport_tx.sv
module adc_sport_tx #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_en_i,
  input  logic              fall_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  output logic              bit_o,
  output logic              word_done_o,
  output logic              word_idle_o
);
  localparam int unsigned      CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] data_q;
  logic [CNT_W-1:0]  cnt_q, pos_q;

  assign word_done_o = shift_en_i & (cnt_q == LAST);
  assign word_idle_o = (cnt_q == '0);
  assign bit_o       = data_q[LAST - pos_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      cnt_q  <= '0;
      pos_q  <= '0;
    end else begin
      if (load_i) data_q <= load_data_i;
      if (shift_en_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      // output bit advances on the falling edge after each sampled bit
      if (word_done_o)  pos_q <= '0;
      else if (fall_i)  pos_q <= cnt_q;
    end
  end

  assert_no_tear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |=> $stable(data_q));
endmodule

// File: rtl/adc_sport_ready.sv
module adc_sport_ready #(
  parameter int unsigned DATA_W       = 16,
  parameter int unsigned BLANK_CYCLES = 500
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              result_valid_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic              word_idle_i,
  input  logic              word_done_i,
  input  logic              rise_i,
  output logic              load_o,
  output logic [DATA_W-1:0] load_data_o,
  output logic              drdy_no
);
  localparam int unsigned   BW     = $clog2(BLANK_CYCLES + 1);
  localparam logic [BW-1:0] B_INIT = BW'(BLANK_CYCLES - 1);
  localparam logic [BW-1:0] B_FULL = BW'(BLANK_CYCLES);

  logic [DATA_W-1:0] hold_q;
  logic [BW-1:0]     blank_q;
  logic              pend_q, drdy_q;

  // no load on a cycle with a serial edge, so a starting word sees one value
  assign load_o      = pend_q & (blank_q == '0) & word_idle_i & ~rise_i & ~result_valid_i;
  assign load_data_o = hold_q;
  assign drdy_no     = drdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q  <= '0;
      blank_q <= '0;
      pend_q  <= 1'b0;
      drdy_q  <= 1'b1;
    end else if (result_valid_i) begin
      hold_q  <= result_i;
      pend_q  <= 1'b1;
      blank_q <= B_INIT;
      drdy_q  <= 1'b1;
    end else begin
      if (blank_q != '0) blank_q <= blank_q - 1'b1;
      if (load_o) begin
        pend_q <= 1'b0;
        drdy_q <= 1'b0;
      end else if (word_done_i) begin
        drdy_q <= 1'b1;
      end
    end
  end

  // cycles since the last result, saturating; checks the blanking window
  logic [BW-1:0] since_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              since_q <= B_FULL;
    else if (result_valid_i)  since_q <= '0;
    else if (since_q < B_FULL) since_q <= since_q + 1'b1;
  end

  assert_drdy_on_result_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_i |=> drdy_no);
  assert_blank_window_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(drdy_no) |-> (since_q >= B_FULL));
  assert_drdy_on_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_done_i |=> drdy_no);
endmodule

// File: rtl/adc_sport_cmd_rx.sv
module adc_sport_cmd_rx #(
  parameter int unsigned CMD_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_en_i,
  input  logic             din_i,
  output logic [CMD_W-1:0] cmd_byte_o,
  output logic             cmd_valid_o
);
  localparam int unsigned     CC_W = $clog2(CMD_W);
  localparam logic [CC_W-1:0] LAST = CC_W'(CMD_W - 1);

  logic [CMD_W-1:0] sr_q, sr_next;
  logic [CC_W-1:0]  cnt_q;

  assign sr_next = {sr_q[CMD_W-2:0], din_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q        <= '0;
      cnt_q       <= '0;
      cmd_byte_o  <= '0;
      cmd_valid_o <= 1'b0;
    end else begin
      cmd_valid_o <= 1'b0;
      if (shift_en_i) begin
        sr_q <= sr_next;
        if (cnt_q == LAST) begin
          cnt_q       <= '0;
          cmd_byte_o  <= sr_next;
          cmd_valid_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assert_cmd_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
  import adc_sport_pkg::*;
#(
  parameter int unsigned DATA_W       = 16,
  parameter int unsigned CMD_W        = 8,
  parameter int unsigned BLANK_CYCLES = 500,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              result_valid_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              din_i,
  output logic              dout_o,
  output logic              dout_en_o,
  output logic              drdy_no,
  output logic [CMD_W-1:0]  cmd_byte_o,
  output logic              cmd_valid_o
);
  ser_evt_t          evt;
  logic              shift_en, tx_bit, word_done, word_idle, load;
  logic [DATA_W-1:0] load_data;

  adc_sport_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .cs_ni, .sclk_i, .din_i, .evt_o(evt)
  );

  assign shift_en = evt.rise & evt.active;

  adc_sport_ready #(.DATA_W(DATA_W), .BLANK_CYCLES(BLANK_CYCLES)) i_ready (
    .clk_i, .rst_ni, .result_valid_i, .result_i,
    .word_idle_i(word_idle), .word_done_i(word_done), .rise_i(evt.rise),
    .load_o(load), .load_data_o(load_data), .drdy_no
  );

  adc_sport_tx #(.DATA_W(DATA_W)) i_tx (
    .clk_i, .rst_ni, .shift_en_i(shift_en), .fall_i(evt.fall),
    .load_i(load), .load_data_i(load_data),
    .bit_o(tx_bit), .word_done_o(word_done), .word_idle_o(word_idle)
  );

  adc_sport_cmd_rx #(.CMD_W(CMD_W)) i_cmd_rx (
    .clk_i, .rst_ni, .shift_en_i(shift_en), .din_i(evt.din),
    .cmd_byte_o, .cmd_valid_o
  );

  assign dout_en_o = evt.active;
  assign dout_o    = evt.active & tx_bit;

  assert_no_capture_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt.active |=> !cmd_valid_o);
endmodule

// File: tb/test_adc_serial_port.sv
module test_adc_serial_port;
  localparam int W = 16;
  localparam int BLANK = 12;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic result_valid_i = 1'b0;
  logic [W-1:0] result_i = '0;
  logic cs_ni = 1'b1, sclk_i = 1'b1, din_i = 1'b0;
  logic dout_o, dout_en_o, drdy_no, cmd_valid_o;
  logic [7:0] cmd_byte_o;

  always #2 clk = ~clk;

  adc_serial_port #(.DATA_W(W), .CMD_W(8), .BLANK_CYCLES(BLANK), .SYNC_STAGES(2)) i_adc_serial_port (
    .clk_i(clk), .rst_ni, .result_valid_i, .result_i, .cs_ni, .sclk_i, .din_i,
    .dout_o, .dout_en_o, .drdy_no, .cmd_byte_o, .cmd_valid_o
  );

  int checks = 0, failures = 0;
  string cur_req = "R1";
  bit run_cmp = 1'b0, done = 1'b0;

  // behavioural model of the port, stepped once per clock
  bit [W-1:0] m_data = '0, m_hold = '0;
  int m_blank = 0, m_bits = 0, m_ccnt = 0;
  bit m_pend = 0, m_drdy = 1, m_cvalid = 0;
  bit [7:0] m_csr = '0, m_cbyte = '0;
  bit h_cs[4] = '{1, 1, 1, 1};
  bit h_sc[4] = '{1, 1, 1, 1};
  bit h_din[4] = '{0, 0, 0, 0};

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_data = '0; m_hold = '0; m_blank = 0; m_bits = 0; m_ccnt = 0;
      m_pend = 0; m_drdy = 1; m_cvalid = 0; m_csr = '0; m_cbyte = '0;
      for (int i = 0; i < 4; i++) begin h_cs[i] = 1; h_sc[i] = 1; h_din[i] = 0; end
    end else begin
      bit act, rise, ld, wdone;
      for (int i = 3; i > 0; i--) begin
        h_cs[i] = h_cs[i-1]; h_sc[i] = h_sc[i-1]; h_din[i] = h_din[i-1];
      end
      h_cs[0] = cs_ni; h_sc[0] = sclk_i; h_din[0] = din_i;
      act   = !h_cs[2];
      rise  = h_sc[2] && !h_sc[3];
      wdone = rise && act && (m_bits == W - 1);
      ld    = m_pend && (m_blank == 0) && (m_bits == 0) && !rise && !result_valid_i;
      if (result_valid_i) begin
        m_hold = result_i; m_pend = 1; m_blank = BLANK - 1; m_drdy = 1;
      end else begin
        if (m_blank > 0) m_blank--;
        if (ld) begin m_data = m_hold; m_pend = 0; m_drdy = 0; end
        else if (wdone) m_drdy = 1;
      end
      m_cvalid = 0;
      if (rise && act) begin
        m_bits = (m_bits + 1) % W;
        m_csr = {m_csr[6:0], h_din[2]};
        m_ccnt++;
        if (m_ccnt == 8) begin m_ccnt = 0; m_cbyte = m_csr; m_cvalid = 1; end
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni && run_cmp) begin
      chk(cur_req, "drdy_no", W'(drdy_no), W'(m_drdy));
      chk(cur_req, "dout_en_o", W'(dout_en_o), W'(!h_cs[1]));
      chk(cur_req, "cmd_valid_o", W'(cmd_valid_o), W'(m_cvalid));
      chk(cur_req, "cmd_byte_o", W'(cmd_byte_o), W'(m_cbyte));
      if (!dout_en_o) chk("R7", "dout_o idle", W'(dout_o), '0);
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_result(input logic [W-1:0] v);
    result_i = v; result_valid_i = 1'b1;
    @(negedge clk);
    result_valid_i = 1'b0;
    chk("R2", "drdy after strobe", W'(drdy_no), W'(1));
  endtask

  // shifts bits first..last of a word; host samples dout just before each rise
  task automatic xfer(input logic [W-1:0] exp, input logic [W-1:0] dbits, input int first,
                      input int last, input bit lower_cs, input bit raise_cs, input string req);
    if (lower_cs) begin cs_ni = 1'b0; wait_n(4); end
    for (int i = first; i <= last; i++) begin
      sclk_i = 1'b0; din_i = dbits[W-1-i];
      wait_n(4);
      chk(req, "dout bit", W'(dout_o), W'(exp[W-1-i]));
      sclk_i = 1'b1;
      wait_n(4);
    end
    wait_n(4);
    if (raise_cs) begin cs_ni = 1'b1; wait_n(4); end
  endtask

  initial begin
    wait_n(3);
    // R1: reset state
    chk("R1", "drdy in reset", W'(drdy_no), W'(1));
    chk("R1", "dout_en in reset", W'(dout_en_o), '0);
    chk("R1", "cmd_valid in reset", W'(cmd_valid_o), '0);
    rst_ni = 1'b1;
    run_cmp = 1'b1;
    wait_n(4);
    chk("R1", "drdy after reset", W'(drdy_no), W'(1));

    // R2, R3: blanking then load
    cur_req = "R3";
    send_result(16'hA5C3);
    wait_n(BLANK - 2);
    chk("R3", "drdy inside window", W'(drdy_no), W'(1));
    wait_n(4);
    chk("R3", "drdy after window", W'(drdy_no), '0);

    // R4, R5, R10: full read with command bytes
    cur_req = "R5";
    xfer(16'hA5C3, 16'h3C96, 0, W - 1, 1, 1, "R4");
    chk("R5", "drdy after word", W'(drdy_no), W'(1));
    chk("R10", "second command byte", W'(cmd_byte_o), W'(8'h96));

    // R11: second result restarts window
    cur_req = "R11";
    send_result(16'h1111);
    wait_n(5);
    send_result(16'h7E01);
    wait_n(BLANK - 2);
    chk("R11", "drdy window restarted", W'(drdy_no), W'(1));
    wait_n(4);
    chk("R11", "drdy after restart", W'(drdy_no), '0);
    xfer(16'h7E01, 16'hFFFF, 0, W - 1, 1, 1, "R11");

    // R6: result due mid-word is deferred
    cur_req = "R6";
    send_result(16'hD00D);
    wait_n(BLANK + 4);
    xfer(16'hD00D, 16'h0000, 0, 7, 1, 0, "R6");
    send_result(16'hBEEF);
    wait_n(BLANK + 6);
    chk("R6", "drdy while deferred", W'(drdy_no), W'(1));
    xfer(16'hD00D, 16'h0000, 8, W - 1, 0, 1, "R6");
    wait_n(4);
    chk("R6", "drdy after deferred load", W'(drdy_no), '0);
    xfer(16'hBEEF, 16'h5AA5, 0, W - 1, 1, 1, "R6");

    // R8: split across chip-select periods, then three-wire reads
    cur_req = "R8";
    send_result(16'h4C2B);
    wait_n(BLANK + 4);
    xfer(16'h4C2B, 16'h1234, 0, 7, 1, 1, "R8");
    wait_n(6);
    chk("R8", "drdy mid split word", W'(drdy_no), '0);
    xfer(16'h4C2B, 16'h1234, 8, W - 1, 1, 1, "R8");
    chk("R8", "drdy after split word", W'(drdy_no), W'(1));
    cs_ni = 1'b0;
    wait_n(4);
    send_result(16'h0F0F);
    wait_n(BLANK + 4);
    xfer(16'h0F0F, 16'hC3C3, 0, W - 1, 0, 0, "R8");
    xfer(16'h0F0F, 16'h00FF, 0, W - 1, 0, 0, "R8");
    chk("R10", "byte in three-wire", W'(cmd_byte_o), W'(8'hFF));

    // R7: driver disabled with chip select high
    cur_req = "R7";
    cs_ni = 1'b1;
    wait_n(3);
    chk("R7", "dout_en off", W'(dout_en_o), '0);
    chk("R7", "dout off", W'(dout_o), '0);
    cs_ni = 1'b0;
    wait_n(3);
    chk("R7", "dout_en on", W'(dout_en_o), W'(1));
    cs_ni = 1'b1;
    wait_n(4);

    // R9: edges with chip select high are ignored
    cur_req = "R9";
    send_result(16'h8421);
    wait_n(BLANK + 4);
    din_i = 1'b1;
    for (int k = 0; k < 5; k++) begin
      sclk_i = 1'b0; wait_n(4);
      sclk_i = 1'b1; wait_n(4);
    end
    chk("R9", "drdy after ignored edges", W'(drdy_no), '0);
    xfer(16'h8421, 16'h6D00, 0, W - 1, 1, 1, "R9");
    chk("R9", "bytes aligned", W'(cmd_byte_o), '0);

    // R1: reset mid-word clears counters
    cur_req = "R1";
    send_result(16'h3E7A);
    wait_n(BLANK + 4);
    xfer(16'h3E7A, 16'hFFFF, 0, 4, 1, 1, "R1");
    rst_ni = 1'b0;
    wait_n(2);
    chk("R1", "drdy in mid reset", W'(drdy_no), W'(1));
    chk("R1", "cmd_byte cleared", W'(cmd_byte_o), '0);
    rst_ni = 1'b1;
    wait_n(4);
    send_result(16'h9C35);
    wait_n(BLANK + 4);
    xfer(16'h9C35, 16'h2481, 0, W - 1, 1, 1, "R1");
    chk("R10", "byte after reset", W'(cmd_byte_o), W'(8'h81));
    chk("R5", "drdy after last word", W'(drdy_no), W'(1));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule